// File: doc/BRIEF.md
# Chained-Table Stream-to-Memory Buffer Writer

This block takes a stream of 32-bit words and stores them in host memory, one buffer page at a time. Buffer pages are found through a ring of table pages held in the same memory. Each table page lists the frame numbers of its buffer pages in order, and the word after the last entry holds the frame number of the next table page. A page holds `PAGE_WORDS` words. The word address of word `i` in the page with frame number `f` is `{f, i}`, so `f` is shifted left by log2(`PAGE_WORDS`).

Software hands a buffer back to the block by writing zero into its final word. The block fills words `0 .. PAGE_WORDS-2` in stream order and then writes the final word last, with a non-zero completion tag. Software therefore sees a finished buffer only after all of its data is in memory. Software also limits how far ahead the block may run. It keeps a count of granted tables, and the block takes one grant each time it enters a table. Commands on a small control port clear the grant count, add one grant, start the ring at a given first table, and stop the ring.

The input is valid/ready. A word moves on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is filling a buffer and has no memory access outstanding. The producer must hold `in_valid` and `in_data` until that happens. When the block cannot go on, `in_ready` stays low and a sticky `overflow` flag is raised. This happens when no grant is left, or when the next buffer's final word is still non-zero. The memory side is one request/acknowledge word port.

Top module: `dma_ring_writer`

## Requirements
- R1: After reset, `active`, `in_ready`, `mem_req` and `overflow` are all 0.
- R2: `cmd_op` 2 (start) with `cmd_valid`, given while the block is idle, loads `first_frame` as the current table. The first memory access after a start is a read of word 0 of that table. A start given while active is ignored.
- R3: `cmd_op` 0 sets the grant count to zero and `cmd_op` 1 adds one grant. Entering a table takes one grant. While no grant is left, the block makes no memory access, holds `in_ready` low and sets `overflow`.
- R4: The buffers of a table are used in order: entries 0 to `BUFS_PER_TABLE-1`. After the last one, the block reads the link word at index `BUFS_PER_TABLE` and enters the table it names.
- R5: Before filling a buffer, the block reads the buffer's final word (index `PAGE_WORDS-1`). If that word is non-zero, the block writes nothing to the buffer, holds `in_ready` low, sets `overflow` and reads the word again. Once it reads zero, it fills the buffer.
- R6: Accepted data words are written to indices 0 to `PAGE_WORDS-2` of the current buffer, in arrival order.
- R7: The final word is written after every data word of the buffer, with value `32'h8000_0000 | n`. Here `n` is the number of buffers completed since the last start, so the first buffer gets 0.
- R8: Once `mem_req` rises, it stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high. Read data is taken from `mem_rdata` in that same cycle.
- R9: Each accepted input word causes exactly one memory write. `in_ready` is never high while a memory request is outstanding.
- R10: `cmd_op` 3 (stop) lets any outstanding access finish. After that, `active` goes low and the block issues no further requests and accepts no words.
- R11: `overflow` stays high until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 clear grants, 1 add grant, 2 start, 3 stop |
| first_frame | input | PFN_W | Frame number of the first table, used by start |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Block can take a word this cycle |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | PFN_W+log2(PAGE_WORDS) | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| active | output | 1 | Ring is running |
| overflow | output | 1 | Sticky stall indicator |

## Verification
The bench starts the ring with zero grants. A design that decremented the grant count without checking it, or that ignored the clear command, would start writing at once instead of stalling. The ring is driven through the wrap from one table to the next and back to the first. There the block meets buffers whose final words are still tagged. A design that skipped the final-word read would overwrite unreleased data, and one that wrote the tag before the data would expose a half-filled buffer. The bench also covers a stop in the middle of a buffer, an ignored start while active, and a restart. These catch a design that drops its request before the acknowledge, keeps issuing requests after a stop, or fails to restart the completion sequence and clear the overflow flag.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

  typedef enum logic [1:0] {
    OP_GRANT_CLR  = 2'd0,
    OP_GRANT_ADD  = 2'd1,
    OP_RING_START = 2'd2,
    OP_RING_STOP  = 2'd3
  } ring_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_ENTRY,
    ST_CHECK,
    ST_FILL,
    ST_TAIL,
    ST_LINK
  } walk_state_e;

  localparam logic [31:0] TAG_MARK = 32'h8000_0000;

  function automatic logic [31:0] done_tag(input logic [30:0] seq);
    return TAG_MARK | {1'b0, seq};
  endfunction

endpackage

// File: rtl/ring_grant_ctr.sv
module ring_grant_ctr #(
  parameter int GRANT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic add,
  input  logic take,
  output logic has_credit
);
  localparam logic [GRANT_W-1:0] CNT_MAX = {GRANT_W{1'b1}};

  logic [GRANT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (add && !take) begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end else if (take && !add) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign has_credit = (cnt != '0);
endmodule

// File: rtl/ring_mem_port.sv
module ring_mem_port #(
  parameter int MA_W = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss,
  input  logic            iss_we,
  input  logic [MA_W-1:0] iss_addr,
  input  logic [31:0]     iss_wdata,
  output logic            busy,
  output logic            done,
  output logic            mem_req,
  output logic            mem_we,
  output logic [MA_W-1:0] mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (mem_req && mem_ack) begin
      mem_req <= 1'b0;
    end else if (iss && !mem_req) begin
      mem_req   <= 1'b1;
      mem_we    <= iss_we;
      mem_addr  <= iss_addr;
      mem_wdata <= iss_wdata;
    end
  end

  assign busy = mem_req;
  assign done = mem_req && mem_ack;
endmodule

// File: rtl/ring_walker.sv
module ring_walker
  import dma_ring_pkg::*;
#(
  parameter int PFN_W      = 20,
  parameter int PAGE_WORDS = 1024,
  parameter int BUFS       = 511
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cmd_valid,
  input  logic [1:0]                            cmd_op,
  input  logic [PFN_W-1:0]                      first_frame,
  input  logic                                  has_credit,
  output logic                                  take,
  input  logic                                  busy,
  input  logic                                  done,
  input  logic [31:0]                           rdata,
  output logic                                  iss,
  output logic                                  iss_we,
  output logic [PFN_W+$clog2(PAGE_WORDS)-1:0]   iss_addr,
  output logic [31:0]                           iss_wdata,
  input  logic                                  in_valid,
  input  logic [31:0]                           in_data,
  output logic                                  in_ready,
  output logic                                  active,
  output logic                                  overflow
);
  localparam int PAGE_AW = $clog2(PAGE_WORDS);
  localparam logic [PAGE_AW-1:0] LAST_IDX   = PAGE_AW'(PAGE_WORDS - 1);
  localparam logic [PAGE_AW-1:0] FINAL_DATA = PAGE_AW'(PAGE_WORDS - 2);
  localparam logic [PAGE_AW-1:0] LINK_IDX   = PAGE_AW'(BUFS);
  localparam logic [PAGE_AW-1:0] LAST_BUF   = PAGE_AW'(BUFS - 1);

  walk_state_e        state;
  logic [PFN_W-1:0]   tbl_pfn;
  logic [PFN_W-1:0]   buf_pfn;
  logic [PAGE_AW-1:0] buf_idx;
  logic [PAGE_AW-1:0] word_idx;
  logic [30:0]        seq;
  logic               ovf;
  logic               unreg_pend;

  logic start_cmd, stop_cmd, can_issue;
  logic unused_rdata_hi;

  assign unused_rdata_hi = ^rdata[31:PFN_W];

  assign start_cmd = cmd_valid && (cmd_op == OP_RING_START) && (state == ST_IDLE);
  assign stop_cmd  = cmd_valid && (cmd_op == OP_RING_STOP) && (state != ST_IDLE);
  assign can_issue = !busy && !unreg_pend;
  assign in_ready  = (state == ST_FILL) && can_issue;
  assign take      = (state == ST_ENTER) && has_credit && !unreg_pend;
  assign active    = (state != ST_IDLE);
  assign overflow  = ovf;

  always_comb begin
    iss       = 1'b0;
    iss_we    = 1'b0;
    iss_addr  = {tbl_pfn, buf_idx};
    iss_wdata = in_data;
    unique case (state)
      ST_ENTRY: begin
        iss      = can_issue;
        iss_addr = {tbl_pfn, buf_idx};
      end
      ST_CHECK: begin
        iss      = can_issue;
        iss_addr = {buf_pfn, LAST_IDX};
      end
      ST_FILL: begin
        iss      = in_valid && in_ready;
        iss_we   = 1'b1;
        iss_addr = {buf_pfn, word_idx};
      end
      ST_TAIL: begin
        iss       = can_issue;
        iss_we    = 1'b1;
        iss_addr  = {buf_pfn, LAST_IDX};
        iss_wdata = done_tag(seq);
      end
      ST_LINK: begin
        iss      = can_issue;
        iss_addr = {tbl_pfn, LINK_IDX};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tbl_pfn    <= '0;
      buf_pfn    <= '0;
      buf_idx    <= '0;
      word_idx   <= '0;
      seq        <= '0;
      ovf        <= 1'b0;
      unreg_pend <= 1'b0;
    end else begin
      if (stop_cmd) unreg_pend <= 1'b1;
      if (state == ST_IDLE) begin
        if (start_cmd) begin
          tbl_pfn    <= first_frame;
          buf_idx    <= '0;
          seq        <= '0;
          ovf        <= 1'b0;
          unreg_pend <= 1'b0;
          state      <= ST_ENTER;
        end
      end else if (unreg_pend && !busy) begin
        state      <= ST_IDLE;
        unreg_pend <= 1'b0;
      end else begin
        unique case (state)
          ST_ENTER: begin
            if (take) state <= ST_ENTRY;
            else if (!has_credit) ovf <= 1'b1;
          end
          ST_ENTRY: if (done) begin
            buf_pfn <= rdata[PFN_W-1:0];
            state   <= ST_CHECK;
          end
          ST_CHECK: if (done) begin
            if (rdata != '0) begin
              ovf <= 1'b1;
            end else begin
              word_idx <= '0;
              state    <= ST_FILL;
            end
          end
          ST_FILL: if (done) begin
            word_idx <= word_idx + 1'b1;
            if (word_idx == FINAL_DATA) state <= ST_TAIL;
          end
          ST_TAIL: if (done) begin
            seq <= seq + 1'b1;
            if (buf_idx == LAST_BUF) begin
              state <= ST_LINK;
            end else begin
              buf_idx <= buf_idx + 1'b1;
              state   <= ST_ENTRY;
            end
          end
          ST_LINK: if (done) begin
            tbl_pfn <= rdata[PFN_W-1:0];
            buf_idx <= '0;
            state   <= ST_ENTER;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_ring_writer.sv
module dma_ring_writer
  import dma_ring_pkg::*;
#(
  parameter int PFN_W          = 20,
  parameter int PAGE_WORDS     = 1024,
  parameter int BUFS_PER_TABLE = 511,
  parameter int GRANT_W        = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cmd_valid,
  input  logic [1:0]                            cmd_op,
  input  logic [PFN_W-1:0]                      first_frame,
  input  logic                                  in_valid,
  input  logic [31:0]                           in_data,
  output logic                                  in_ready,
  output logic                                  mem_req,
  output logic                                  mem_we,
  output logic [PFN_W+$clog2(PAGE_WORDS)-1:0]   mem_addr,
  output logic [31:0]                           mem_wdata,
  input  logic                                  mem_ack,
  input  logic [31:0]                           mem_rdata,
  output logic                                  active,
  output logic                                  overflow
);
  localparam int PAGE_AW = $clog2(PAGE_WORDS);
  localparam int MA_W    = PFN_W + PAGE_AW;

  logic            g_clr, g_add, g_take, g_has;
  logic            p_iss, p_we, p_busy, p_done;
  logic [MA_W-1:0] p_addr;
  logic [31:0]     p_wdata;

  assign g_clr = cmd_valid && (cmd_op == OP_GRANT_CLR);
  assign g_add = cmd_valid && (cmd_op == OP_GRANT_ADD);

  ring_grant_ctr #(.GRANT_W(GRANT_W)) u_grant (
    .clk(clk), .rst_n(rst_n), .clr(g_clr), .add(g_add),
    .take(g_take), .has_credit(g_has)
  );

  ring_mem_port #(.MA_W(MA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .iss(p_iss), .iss_we(p_we),
    .iss_addr(p_addr), .iss_wdata(p_wdata), .busy(p_busy), .done(p_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack)
  );

  ring_walker #(.PFN_W(PFN_W), .PAGE_WORDS(PAGE_WORDS), .BUFS(BUFS_PER_TABLE)) u_walk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .first_frame(first_frame), .has_credit(g_has), .take(g_take),
    .busy(p_busy), .done(p_done), .rdata(mem_rdata), .iss(p_iss),
    .iss_we(p_we), .iss_addr(p_addr), .iss_wdata(p_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .active(active), .overflow(overflow)
  );
endmodule

// File: rtl/dma_ring_writer_chk.sv
module dma_ring_writer_chk #(
  parameter int MA_W    = 30,
  parameter int PAGE_AW = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic            in_ready,
  input logic            mem_req,
  input logic            mem_we,
  input logic [MA_W-1:0] mem_addr,
  input logic [31:0]     mem_wdata,
  input logic            mem_ack,
  input logic            active,
  input logic            overflow
);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mem_req && !in_ready);

  p_tail_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && (&mem_addr[PAGE_AW-1:0]) |-> mem_wdata[31]);

  p_ready_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req);

  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !(cmd_valid && cmd_op == 2'd2 && !active) |=> overflow);

  p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd2 && !active |=> !overflow && active);
endmodule

bind dma_ring_writer dma_ring_writer_chk #(.MA_W(MA_W), .PAGE_AW(PAGE_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .active(active), .overflow(overflow)
);

// File: tb/dma_ring_writer_test.sv
module dma_ring_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int PFN_W      = 12;
  localparam int PAGE_WORDS = 8;
  localparam int BUFS       = 3;
  localparam int MA_W       = 15;
  localparam int DATA_N     = PAGE_WORDS - 1;

  logic clk, rst_n, cmd_valid, in_valid, in_ready;
  logic [1:0] cmd_op;
  logic [PFN_W-1:0] first_frame;
  logic [31:0] in_data, mem_wdata, mem_rdata;
  logic mem_req, mem_we, mem_ack, active, overflow;
  logic [MA_W-1:0] mem_addr;

  dma_ring_writer #(.PFN_W(PFN_W), .PAGE_WORDS(PAGE_WORDS), .BUFS_PER_TABLE(BUFS), .GRANT_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .first_frame(first_frame), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .active(active), .overflow(overflow)
  );

  int unsigned mem [int unsigned];
  int unsigned expw [int unsigned];
  int unsigned log_addr [$];
  bit          log_we [$];
  int errors = 0;
  int checks = 0;
  bit hold_bad = 0;

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic int unsigned wa(int unsigned pfn, int unsigned idx);
    return pfn * PAGE_WORDS + idx;
  endfunction

  function automatic int unsigned tag(int unsigned n);
    return 32'h8000_0000 | n;
  endfunction

  function automatic int unsigned rd(int unsigned a);
    return mem.exists(a) ? mem[a] : 0;
  endfunction

  function automatic int count_writes(int unsigned pfn, int from);
    int n = 0;
    for (int i = from; i < log_addr.size(); i++)
      if (log_we[i] && (log_addr[i] / PAGE_WORDS) == pfn) n++;
    return n;
  endfunction

  function automatic bit saw_read(int unsigned a);
    foreach (log_addr[i]) if (!log_we[i] && log_addr[i] == a) return 1;
    return 0;
  endfunction

  function automatic bit tail_last(int unsigned pfn);
    int t = -1;
    foreach (log_addr[i]) if (log_we[i] && log_addr[i] == wa(pfn, PAGE_WORDS-1)) t = i;
    if (t < 0) return 0;
    foreach (log_addr[i])
      if (log_we[i] && (log_addr[i] / PAGE_WORDS) == pfn && i > t) return 0;
    return 1;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // memory responder with random latency
  initial begin
    int unsigned dly;
    bit pend;
    logic [MA_W-1:0] ha;
    logic [31:0] hd;
    logic hw;
    pend = 0; dly = 0; ha = '0; hd = '0; hw = 0;
    mem_ack = 0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req) begin
        if (!pend) begin
          pend = 1; dly = $urandom_range(0, 2);
          ha = mem_addr; hd = mem_wdata; hw = mem_we;
        end else if (ha != mem_addr || hd != mem_wdata || hw != mem_we) begin
          hold_bad = 1;
        end
        if (dly == 0) begin
          mem_ack = 1;
          pend = 0;
          log_addr.push_back(int'(mem_addr));
          log_we.push_back(mem_we);
          if (mem_we) mem[int'(mem_addr)] = mem_wdata;
          else mem_rdata = rd(int'(mem_addr));
        end else dly--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic send_cmd(logic [1:0] op, logic [PFN_W-1:0] fr);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; first_frame = fr;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_ready(output bit ok);
    ok = 0;
    for (int i = 0; i < 80; i++) begin
      if (in_ready) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic push(logic [31:0] w);
    in_valid = 1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic push_fill(int unsigned pfn, int n);
    for (int i = 0; i < n; i++) begin
      int unsigned w = $urandom;
      expw[wa(pfn, i)] = w;
      push(w);
    end
  endtask

  task automatic check_buf(int unsigned pfn, int unsigned n);
    for (int i = 0; i < DATA_N; i++)
      chk("R6", $sformatf("data %0h[%0d]", pfn, i), rd(wa(pfn, i)), expw[wa(pfn, i)]);
    chk("R7", $sformatf("tag of %0h", pfn), rd(wa(pfn, PAGE_WORDS-1)), tag(n));
  endtask

  initial begin
    bit ok;
    int base, n0;
    void'($urandom(32'd1234));
    rst_n = 0; cmd_valid = 0; cmd_op = 0; first_frame = 0; in_valid = 0; in_data = 0;
    // ring: table 0x010 -> 0x020 -> 0x010
    mem[wa(12'h010, 0)] = 32'h100; mem[wa(12'h010, 1)] = 32'h101;
    mem[wa(12'h010, 2)] = 32'h102; mem[wa(12'h010, 3)] = 32'h020;
    mem[wa(12'h020, 0)] = 32'h200; mem[wa(12'h020, 1)] = 32'h201;
    mem[wa(12'h020, 2)] = 32'h202; mem[wa(12'h020, 3)] = 32'h010;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "active", active, 0);
    chk("R1", "in_ready", in_ready, 0);
    chk("R1", "mem_req", mem_req, 0);
    chk("R1", "overflow", overflow, 0);

    // R3: grants added then cleared -> start stalls
    send_cmd(2'd1, 0); send_cmd(2'd1, 0); send_cmd(2'd0, 0);
    send_cmd(2'd2, 12'h010);
    repeat (30) @(negedge clk);
    chk("R3", "active after start", active, 1);
    chk("R3", "in_ready with no grant", in_ready, 0);
    chk("R3", "overflow with no grant", overflow, 1);
    chk("R3", "accesses with no grant", log_addr.size(), 0);

    send_cmd(2'd1, 0);
    wait_ready(ok);
    chk("R3", "proceeds after grant", ok, 1);
    chk("R2", "first access is table word 0", log_addr[0], wa(12'h010, 0));
    chk("R2", "first access is a read", log_we[0], 0);
    chk("R5", "final word read before fill", log_addr[1], wa(12'h100, PAGE_WORDS-1));
    chk("R11", "overflow still set", overflow, 1);

    send_cmd(2'd2, 12'h077); // ignored while active
    push_fill(12'h100, DATA_N); push_fill(12'h101, DATA_N); push_fill(12'h102, DATA_N);
    repeat (40) @(negedge clk);
    chk("R3", "stall at table without grant", in_ready, 0);
    check_buf(12'h100, 0); check_buf(12'h101, 1); check_buf(12'h102, 2);
    chk("R7", "tag written last", tail_last(12'h100) && tail_last(12'h101) && tail_last(12'h102), 1);
    chk("R9", "one write per word",
        count_writes(12'h100, 0) + count_writes(12'h101, 0) + count_writes(12'h102, 0), 3 * PAGE_WORDS);
    chk("R4", "link word read", saw_read(wa(12'h010, BUFS)), 1);
    chk("R2", "ignored start touched nothing", count_writes(12'h077, 0) + saw_read(wa(12'h077, 0)), 0);

    send_cmd(2'd1, 0);
    wait_ready(ok);
    chk("R4", "entered linked table", ok && saw_read(wa(12'h020, 0)), 1);
    push_fill(12'h200, DATA_N); push_fill(12'h201, DATA_N); push_fill(12'h202, DATA_N);
    repeat (40) @(negedge clk);
    check_buf(12'h200, 3); check_buf(12'h201, 4); check_buf(12'h202, 5);

    // wrap to first table, buffer still tagged
    n0 = log_addr.size();
    send_cmd(2'd1, 0);
    repeat (40) @(negedge clk);
    chk("R5", "stall on tagged buffer", in_ready, 0);
    chk("R5", "no write into tagged buffer", count_writes(12'h100, n0), 0);
    chk("R5", "overflow on tagged buffer", overflow, 1);
    mem[wa(12'h100, PAGE_WORDS-1)] = 0;
    wait_ready(ok);
    chk("R5", "fill after release", ok, 1);
    push_fill(12'h100, 3);
    repeat (10) @(negedge clk);
    for (int i = 0; i < 3; i++)
      chk("R6", "refill data", rd(wa(12'h100, i)), expw[wa(12'h100, i)]);

    // stop mid-buffer
    send_cmd(2'd3, 0);
    repeat (15) @(negedge clk);
    chk("R10", "active after stop", active, 0);
    chk("R10", "in_ready after stop", in_ready, 0);
    chk("R10", "mem_req after stop", mem_req, 0);
    n0 = log_addr.size();
    repeat (20) @(negedge clk);
    chk("R10", "no access after stop", log_addr.size(), n0);

    // restart at second table
    mem[wa(12'h200, PAGE_WORDS-1)] = 0;
    send_cmd(2'd1, 0);
    base = log_addr.size();
    send_cmd(2'd2, 12'h020);
    chk("R11", "start clears overflow", overflow, 0);
    wait_ready(ok);
    chk("R2", "restart reads new first table", ok && log_addr[base] == wa(12'h020, 0), 1);
    push_fill(12'h200, DATA_N);
    repeat (20) @(negedge clk);
    check_buf(12'h200, 0);
    chk("R8", "request held until ack", hold_bad, 0);
    report();
  end
endmodule